// File: doc/BRIEF.md
# Serial ATA Frame Type Acceptance Filter

This block sits on the receive side of a Serial ATA host port. It watches a dword stream that carries frame start, frame end and error flags. From the type byte in the first dword of each frame it picks one of fifteen 2-bit policy registers, and from that register it decides whether the frame is taken, refused, or taken and held for the host. When the last dword of the frame arrives, the block issues one reply toward the device: good or bad. In the same cycle it tells the receive buffer whether to keep or drop the frame, and it signals the host where that is needed.

The policy registers are written through a simple index/value port. Each frame type has its own reset default. A BIST request frame is accepted only when it asks for far-end retimed loopback. The decision is fixed when the frame starts, so a policy write made during a frame applies only to later frames.

Top module: `fis_filter`

## Requirements
- R1: Type byte `rx_data_i[7:0]` of the start dword selects a policy slot: 27h=0, 34h=1, 39h=2, 41h=3, 46h=4, 58h=5, 5Fh=6, A1h=7, A6h=8, B8h=9, BFh=10, C7h=11, D4h=12, D9h=13, and any other code=14. Policy 00b accepts the frame without holding it.
- R2: After reset, slots 0 and 3 and slots 8 to 14 hold 01b (refuse). Slots 1, 2, 4, 5, 6 and 7 hold 00b (accept).
- R3: A refused frame gives `reply_err_o`, `buf_drop_o`, no `host_notify_o`, and no change to `interlock_o`.
- R4: An accepted frame with `rx_err_i` seen on any of its dwords gives `reply_err_o` and `buf_drop_o`, with no `host_notify_o`.
- R5: Policy 10b or 11b accepts the frame and holds it. An error-free frame gives `reply_ok_o`, and `interlock_o` is set and stays high until `ilk_ack_i` is asserted.
- R6: A type 58h frame is refused whenever its slot is 00b and its pattern byte `rx_data_i[23:16]` is not exactly 0Ah, where bit 3 is F and bit 1 is R, both set, with all other bits clear.
- R7: The reply is a one-cycle pulse in the cycle after the end dword is sampled. Exactly one of `reply_ok_o` and `reply_err_o` is high, and a frame of a single dword (start and end together) is handled the same way.
- R8: The policy is sampled on the start dword and held until the reply. A policy write during a frame, or in the same cycle as its start dword, affects only later frames.
- R9: A write with `cfg_we_i` high stores `cfg_val_i` into slot `cfg_idx_i` for indexes 0 to 14. Index 15 changes no slot.
- R10: Dwords with `rx_valid_i` high that arrive outside a frame, without a start flag, produce no reply.
- R11: An accepted, error-free frame pulses `buf_keep_o` and `host_notify_o` together with `reply_ok_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Dword valid |
| rx_sof_i | input | 1 | First dword of frame |
| rx_eof_i | input | 1 | Last dword of frame |
| rx_err_i | input | 1 | CRC or other error flag on this dword |
| rx_data_i | input | 32 | Received dword |
| cfg_we_i | input | 1 | Policy write strobe |
| cfg_idx_i | input | 4 | Policy slot index |
| cfg_val_i | input | 2 | Policy value |
| ilk_ack_i | input | 1 | Host releases held frame |
| reply_ok_o | output | 1 | Good reply pulse |
| reply_err_o | output | 1 | Bad reply pulse |
| buf_keep_o | output | 1 | Keep frame in receive buffer |
| buf_drop_o | output | 1 | Drop frame from receive buffer |
| host_notify_o | output | 1 | Host notification pulse |
| interlock_o | output | 1 | Held frame awaiting host |

## Verification
The bench targets the reset table first: a design that swaps defaults would give a good reply for a type 27h or a reserved code. It sends BIST frames with near-miss pattern bytes (F alone, F and R with an extra bit), which a loose mask would wrongly accept. A policy write made in the middle of a frame must leave that frame's reply unchanged; a design that looks the policy up again at the end would flip it. Single-dword frames, errors on an accepted frame, writes to index 15, and stray dwords outside a frame show off-by-one, sticky-error and decode faults.

// File: rtl/fis_filter_pkg.sv
package fis_filter_pkg;
  localparam int NUM_SLOTS = 15;
  localparam int IDX_W     = 4;
  localparam int POL_W     = 2;
  localparam int DW_W      = 32;

  localparam logic [7:0] BIST_CODE    = 8'h58;
  localparam logic [7:0] BIST_FAR_RET = 8'h0A;

  typedef enum logic [1:0] {
    DEC_ACCEPT = 2'd0,
    DEC_REJECT = 2'd1,
    DEC_HOLD   = 2'd2
  } dec_e;

  function automatic logic [IDX_W-1:0] type_to_slot(input logic [7:0] code);
    logic [IDX_W-1:0] s;
    case (code)
      8'h27:   s = 4'd0;
      8'h34:   s = 4'd1;
      8'h39:   s = 4'd2;
      8'h41:   s = 4'd3;
      8'h46:   s = 4'd4;
      8'h58:   s = 4'd5;
      8'h5F:   s = 4'd6;
      8'hA1:   s = 4'd7;
      8'hA6:   s = 4'd8;
      8'hB8:   s = 4'd9;
      8'hBF:   s = 4'd10;
      8'hC7:   s = 4'd11;
      8'hD4:   s = 4'd12;
      8'hD9:   s = 4'd13;
      default: s = 4'd14;
    endcase
    return s;
  endfunction

  function automatic logic [POL_W-1:0] slot_default(input int slot);
    case (slot)
      1, 2, 4, 5, 6, 7: return 2'b00;
      default:          return 2'b01;
    endcase
  endfunction
endpackage

// File: rtl/fis_cfg_regs.sv
module fis_cfg_regs
  import fis_filter_pkg::*;
#(
  parameter int N  = NUM_SLOTS,
  parameter int IW = IDX_W,
  parameter int PW = POL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [PW-1:0]   val_i,
  output logic [N*PW-1:0] cfg_o
);
  logic [PW-1:0] slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= slot_default(g);
      else if (we_i && (int'(idx_i) == g))         slot_q[g] <= val_i;
    end
    assign cfg_o[g*PW +: PW] = slot_q[g];

    AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && int'(idx_i) == g) |=> (slot_q[g] == $past(val_i))); // R9
    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && int'(idx_i) == g) |=> $stable(slot_q[g])); // R9
  end
endmodule

// File: rtl/fis_classifier.sv
module fis_classifier
  import fis_filter_pkg::*;
#(
  parameter int N  = NUM_SLOTS,
  parameter int PW = POL_W,
  parameter int DW = DW_W
) (
  input  logic [DW-1:0]   dw0_i,
  input  logic [N*PW-1:0] cfg_i,
  output dec_e            dec_o
);
  logic [IDX_W-1:0] slot;
  logic [PW-1:0]    pol;
  logic             is_bist, bist_ok;

  assign slot    = type_to_slot(dw0_i[7:0]);
  assign pol     = cfg_i[int'(slot)*PW +: PW];
  assign is_bist = (dw0_i[7:0] == BIST_CODE);
  assign bist_ok = (dw0_i[23:16] == BIST_FAR_RET);

  always_comb begin
    if (pol == 2'b01)           dec_o = DEC_REJECT;
    else if (is_bist && !bist_ok) dec_o = DEC_REJECT;
    else if (pol[1])            dec_o = DEC_HOLD;
    else                        dec_o = DEC_ACCEPT;
  end
endmodule

// File: rtl/fis_reply_ctrl.sv
module fis_reply_ctrl
  import fis_filter_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sof_i,
  input  logic eof_i,
  input  logic err_i,
  input  dec_e dec_i,
  input  logic ilk_ack_i,
  output logic reply_ok_o,
  output logic reply_err_o,
  output logic keep_o,
  output logic drop_o,
  output logic notify_o,
  output logic interlock_o
);
  logic in_frame_q, err_q, ok_q, bad_q, ilk_q;
  dec_e dec_q;
  logic start, fin, eff_err, good;
  dec_e eff_dec;

  assign start   = valid_i && sof_i;
  assign fin     = valid_i && eof_i && (in_frame_q || start);
  assign eff_dec = start ? dec_i : dec_q;
  assign eff_err = err_i || (!start && err_q);
  assign good    = (eff_dec != DEC_REJECT) && !eff_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      dec_q      <= DEC_REJECT;
      err_q      <= 1'b0;
    end else begin
      if (start) begin
        dec_q <= dec_i;
        err_q <= err_i;
      end else if (in_frame_q && valid_i) begin
        err_q <= err_q || err_i;
      end
      if (fin)        in_frame_q <= 1'b0;
      else if (start) in_frame_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
      ilk_q <= 1'b0;
    end else begin
      ok_q  <= fin && good;
      bad_q <= fin && !good;
      if (fin && good && eff_dec == DEC_HOLD) ilk_q <= 1'b1;
      else if (ilk_ack_i)                     ilk_q <= 1'b0;
    end
  end

  assign reply_ok_o  = ok_q;
  assign reply_err_o = bad_q;
  assign keep_o      = ok_q;
  assign drop_o      = bad_q;
  assign notify_o    = ok_q;
  assign interlock_o = ilk_q;

  AST_ONE_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_q, bad_q})); // R7
  AST_REJECT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !start && dec_q == DEC_REJECT) |=> bad_q); // R3
  AST_ERR_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && err_i) |=> (bad_q && !ok_q)); // R4
  AST_ILK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ilk_q) |-> ok_q); // R5
  AST_NO_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_frame_q && !sof_i) |=> (!ok_q && !bad_q)); // R10
endmodule

// File: rtl/fis_filter.sv
module fis_filter
  import fis_filter_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              rx_err_i,
  input  logic [DW_W-1:0]   rx_data_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [POL_W-1:0]  cfg_val_i,
  input  logic              ilk_ack_i,
  output logic              reply_ok_o,
  output logic              reply_err_o,
  output logic              buf_keep_o,
  output logic              buf_drop_o,
  output logic              host_notify_o,
  output logic              interlock_o
);
  logic [NUM_SLOTS*POL_W-1:0] cfg;
  dec_e                       dec;

  fis_cfg_regs #(.N(NUM_SLOTS), .IW(IDX_W), .PW(POL_W)) u_cfg (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .we_i (cfg_we_i), .idx_i (cfg_idx_i), .val_i (cfg_val_i),
    .cfg_o (cfg)
  );

  fis_classifier #(.N(NUM_SLOTS), .PW(POL_W), .DW(DW_W)) u_cls (
    .dw0_i (rx_data_i), .cfg_i (cfg), .dec_o (dec)
  );

  fis_reply_ctrl u_ctl (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .valid_i (rx_valid_i), .sof_i (rx_sof_i), .eof_i (rx_eof_i), .err_i (rx_err_i),
    .dec_i (dec), .ilk_ack_i (ilk_ack_i),
    .reply_ok_o (reply_ok_o), .reply_err_o (reply_err_o),
    .keep_o (buf_keep_o), .drop_o (buf_drop_o),
    .notify_o (host_notify_o), .interlock_o (interlock_o)
  );

  AST_NOTIFY_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_notify_o |-> (reply_ok_o && buf_keep_o && !buf_drop_o)); // R11
endmodule

// File: tb/sim_fis_filter.sv
module sim_fis_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 0, sof = 0, eof = 0, err = 0, we = 0, ack = 0;
  logic [31:0] d = '0;
  logic [3:0] idx = '0;
  logic [1:0] val = '0;
  logic r_ok, r_err, keep, drop, ntf, ilk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fis_filter u0 (
    .clk_i (clk), .rst_ni (rst_n), .rx_valid_i (v), .rx_sof_i (sof), .rx_eof_i (eof),
    .rx_err_i (err), .rx_data_i (d), .cfg_we_i (we), .cfg_idx_i (idx), .cfg_val_i (val),
    .ilk_ack_i (ack), .reply_ok_o (r_ok), .reply_err_o (r_err), .buf_keep_o (keep),
    .buf_drop_o (drop), .host_notify_o (ntf), .interlock_o (ilk)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b {ok,err,keep,drop,notify,ilk}", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {r_ok, r_err, keep, drop, ntf, ilk};
  endfunction

  function automatic logic [5:0] good(input logic il);
    return {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, il};
  endfunction

  function automatic logic [5:0] bad(input logic il);
    return {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, il};
  endfunction

  task automatic wr(input int i, input logic [1:0] x);
    @(negedge clk); we = 1; idx = 4'(i); val = x;
    @(negedge clk); we = 0;
  endtask

  // send frame of n dwords; err on last dword; optional mid-frame write
  task automatic frame(input logic [7:0] code, input logic [7:0] pat, input int n,
                       input logic e, input int wr_i, input logic [1:0] wr_v,
                       output logic [5:0] res);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      v = 1; sof = (k == 0); eof = (k == n-1); err = e && (k == n-1);
      d = (k == 0) ? {8'h00, pat, 8'h00, code} : 32'hA5A5_0000 + k;
      we = (wr_i >= 0) && (k == 1 || n == 1); idx = 4'(wr_i); val = wr_v;
    end
    @(negedge clk);
    v = 0; sof = 0; eof = 0; err = 0; we = 0;
    res = outs();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset outputs", outs(), 6'b0);
  endtask

  task automatic t_defaults();
    logic [5:0] r;
    frame(8'h27, 0, 1, 0, -1, 0, r); chk("R2 27h refused", r, bad(0));
    frame(8'h34, 0, 3, 0, -1, 0, r); chk("R2 34h accepted", r, good(0));
    frame(8'h41, 0, 2, 0, -1, 0, r); chk("R2 41h refused", r, bad(0));
    frame(8'hA6, 0, 2, 0, -1, 0, r); chk("R2 A6h refused", r, bad(0));
    frame(8'h00, 0, 2, 0, -1, 0, r); chk("R1 other code refused", r, bad(0));
    frame(8'h46, 0, 6, 0, -1, 0, r); chk("R1 R11 46h accepted", r, good(0));
    frame(8'hA1, 0, 1, 0, -1, 0, r); chk("R7 single dword A1h", r, good(0));
  endtask

  task automatic t_bist();
    logic [5:0] r;
    frame(8'h58, 8'h0A, 3, 0, -1, 0, r); chk("R6 far retimed ok", r, good(0));
    frame(8'h58, 8'h08, 3, 0, -1, 0, r); chk("R6 F only refused", r, bad(0));
    frame(8'h58, 8'h0B, 3, 0, -1, 0, r); chk("R6 extra bit refused", r, bad(0));
  endtask

  task automatic t_error();
    logic [5:0] r;
    frame(8'h39, 0, 4, 1, -1, 0, r); chk("R4 error on accepted", r, bad(0));
    frame(8'h39, 0, 2, 0, -1, 0, r); chk("R4 error not sticky", r, good(0));
  endtask

  task automatic t_interlock();
    logic [5:0] r;
    wr(0, 2'b10);
    frame(8'h27, 0, 2, 0, -1, 0, r); chk("R5 hold accepted", r, good(1));
    chk("R5 interlock stays", outs(), 6'b000001);
    frame(8'h27, 0, 2, 1, -1, 0, r); chk("R4 R5 held with error", r, bad(1));
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
    chk("R5 ack clears", outs(), 6'b0);
    wr(0, 2'b01);
    frame(8'h27, 0, 2, 0, -1, 0, r); chk("R3 R9 refused again", r, bad(0));
  endtask

  task automatic t_midwrite();
    logic [5:0] r;
    frame(8'h39, 0, 4, 0, 2, 2'b01, r); chk("R8 mid-frame write ignored", r, good(0));
    frame(8'h39, 0, 2, 0, -1, 0, r);     chk("R8 next frame uses write", r, bad(0));
    frame(8'h5F, 0, 1, 0, 6, 2'b01, r);  chk("R8 write with start ignored", r, good(0));
    frame(8'h5F, 0, 1, 0, -1, 0, r);     chk("R8 R9 slot 6 now refuses", r, bad(0));
  endtask

  task automatic t_idx15();
    logic [5:0] r;
    wr(15, 2'b00);
    frame(8'h13, 0, 2, 0, -1, 0, r); chk("R9 index 15 ignored", r, bad(0));
    wr(14, 2'b00);
    frame(8'h13, 0, 2, 0, -1, 0, r); chk("R1 R9 slot 14 written", r, good(0));
  endtask

  task automatic t_stray();
    @(negedge clk); v = 1; eof = 1; d = 32'h0000_0034;
    @(negedge clk); v = 0; eof = 0;
    chk("R10 stray dword no reply", outs(), 6'b0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_bist();
    t_error();
    t_interlock();
    t_midwrite();
    t_idx15();
    t_stray();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule